// File: doc/BRIEF.md
# DMA Channel Bus-Mode Sequencer

This block is the transfer engine of one DMA channel working in dual-address fashion. After a start pulse it latches a source address, a destination address, a unit count and a unit size, asks a system arbiter for the bus, and moves each unit as a read at the source followed by a write at the destination. A request handshake (request, grant) sets up bus ownership. A per-beat completion strobe paces each bus cycle. The current addresses are presented on the ports as the transfer proceeds.

Two bus policies are offered. In burst policy the engine holds the bus from the grant until the last unit is written. In cycle-steal policy it drops the request after every unit and asks again. The trigger is either automatic or an active-low level request line. With the level trigger in burst policy, a request line that goes high pauses the engine once the unit in flight is finished. The engine then resumes from the same addresses when the line falls again. A channel-number parameter above 3 disables the level trigger.

Top module: `dma_seq`

## Requirements
- R1: After reset, bus_req, cyc_valid and xfer_end are low and cur_src and cur_dst are zero.
- R2: A start pulse with a nonzero count loads the settings and begins requesting the bus; a start pulse with a zero count is ignored and bus_req stays low.
- R3: Every unit is carried out as read cycles (cyc_write low) at the source followed by write cycles (cyc_write high) at the destination, and a unit never begins with a write.
- R4: Size code 0, 1, 2 and 3 select 8, 16, 32 and 128 bits; size 3 runs four read beats at source offsets 0, 4, 8, 12 then four write beats at the same destination offsets, with cyc_width reporting 2 (4 bytes). Codes 0 to 2 report their own code on cyc_width.
- R5: After the last write beat of a unit, both addresses advance by 1, 2, 4 or 16 bytes for size codes 0 to 3.
- R6: In burst policy with the automatic trigger, bus_req stays high from the grant until the last unit completes, so it falls exactly once per transfer; cyc_valid is never high without bus_req.
- R7: In cycle-steal policy, bus_req goes low for one cycle after each unit, then rises again, so a transfer of N units shows N falling edges.
- R8: With the level trigger selected, bus_req is asserted while waiting for a grant only when ext_req_n is low.
- R9: With the level trigger in burst policy, if ext_req_n is high when a unit completes, the bus is released; addresses stay unchanged during the pause, and the transfer continues when ext_req_n is low again.
- R10: When the final unit completes, xfer_end is high for exactly one cycle with bus_req low, and the engine returns to idle.
- R11: With the channel-number parameter above 3, ext_mode is ignored and the automatic trigger is used.
- R12: A read or write cycle keeps its address, direction and width until bus_done is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a transfer when idle |
| src_addr | input | AW | First source address |
| dst_addr | input | AW | First destination address |
| xfer_count | input | CW | Number of units to move |
| xfer_size | input | 2 | Unit size code: 0=8, 1=16, 2=32, 3=128 bits |
| burst_mode | input | 1 | 1 selects burst policy, 0 cycle-steal |
| ext_mode | input | 1 | 1 selects the level-detected request line as trigger |
| ext_req_n | input | 1 | Active-low level request line |
| bus_gnt | input | 1 | Arbiter grant |
| bus_done | input | 1 | Current bus beat completes this cycle |
| bus_req | output | 1 | Bus request, held while the bus is owned |
| cyc_valid | output | 1 | A bus beat is being presented |
| cyc_write | output | 1 | 1 for a write beat, 0 for a read beat |
| cyc_addr | output | AW | Address of the current beat |
| cyc_width | output | 2 | Beat width code: 0=1, 1=2, 2=4 bytes |
| cur_src | output | AW | Current source address of the unit |
| cur_dst | output | AW | Current destination address of the unit |
| xfer_end | output | 1 | One-cycle flag when the count is exhausted |

## Verification
The checker relies on burst_mode and ext_mode staying constant from the start pulse until xfer_end. It also relies on the arbiter asserting grant and completion only as plain level inputs that the engine samples in the right states. The stimulus changes the settings only while the engine is idle. The grant and completion lines are driven from a free-running pseudo-random sequence, so stalls of varying length appear at every phase of a unit. The request line is moved only at half-cycle points, including a high stretch in the middle of a level-triggered burst.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_B8   = 2'd0,
    SZ_B16  = 2'd1,
    SZ_B32  = 2'd2,
    SZ_B128 = 2'd3
  } unit_size_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASK,
    S_READ,
    S_WRITE,
    S_DROP,
    S_DONE
  } seq_state_e;

  // bytes moved per unit
  function automatic logic [4:0] unit_bytes(unit_size_e s);
    case (s)
      SZ_B8:   return 5'd1;
      SZ_B16:  return 5'd2;
      SZ_B32:  return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // index of the final 32-bit beat within one direction of a unit
  function automatic logic [1:0] final_beat(unit_size_e s);
    return (s == SZ_B128) ? 2'd3 : 2'd0;
  endfunction

endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  unit_size_e    size_q,
  input  logic          sel_dst,
  input  logic [1:0]    beat,
  output logic          last_unit,
  output logic [AW-1:0] beat_addr,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q
);

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_d, dst_d;
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] inc;

  assign inc = {{(AW-5){1'b0}}, unit_bytes(size_q)};

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    if (load) begin
      src_d = src_in;
      dst_d = dst_in;
      cnt_d = cnt_in;
    end else if (step) begin
      src_d = src_q + inc;
      dst_d = dst_q + inc;
      cnt_d = cnt_q - {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load || step) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_unit = (cnt_q == {{(CW-1){1'b0}}, 1'b1});
  assign beat_addr = (sel_dst ? dst_q : src_q) + {{(AW-4){1'b0}}, beat, 2'b00};

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_zero,
  input  logic [1:0] size_in,
  input  logic       burst_in,
  input  logic       ext_in,
  input  logic       ext_req_n,
  input  logic       bus_gnt,
  input  logic       bus_done,
  input  logic       last_unit,
  output logic       load,
  output logic       step,
  output unit_size_e size_q,
  output logic [1:0] beat_q,
  output logic       bus_req,
  output logic       cyc_valid,
  output logic       cyc_write,
  output logic [1:0] cyc_width,
  output logic       xfer_end
);

  seq_state_e st_q, st_d;
  logic [1:0] beat_d;
  logic       burst_q, ext_q;
  logic       trig;
  logic       beat_last;

  assign trig      = !ext_q || !ext_req_n;
  assign beat_last = (beat_q == final_beat(size_q));

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    load   = 1'b0;
    step   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start && !cnt_zero) begin
          load = 1'b1;
          st_d = S_ASK;
        end
      end
      S_ASK: begin
        if (trig && bus_gnt) begin
          st_d   = S_READ;
          beat_d = 2'd0;
        end
      end
      S_READ: begin
        if (bus_done) begin
          if (beat_last) begin
            st_d   = S_WRITE;
            beat_d = 2'd0;
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      S_WRITE: begin
        if (bus_done) begin
          if (beat_last) begin
            step   = 1'b1;
            beat_d = 2'd0;
            if (last_unit)                         st_d = S_DONE;
            else if (!burst_q || (ext_q && ext_req_n)) st_d = S_DROP;
            else                                   st_d = S_READ;
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      S_DROP:  st_d = S_ASK;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      beat_q <= 2'd0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= SZ_B8;
      burst_q <= 1'b0;
      ext_q   <= 1'b0;
    end else if (load) begin
      size_q  <= unit_size_e'(size_in);
      burst_q <= burst_in;
      ext_q   <= ext_in;
    end
  end

  assign cyc_valid = (st_q == S_READ) || (st_q == S_WRITE);
  assign cyc_write = (st_q == S_WRITE);
  assign bus_req   = cyc_valid || ((st_q == S_ASK) && trig);
  assign xfer_end  = (st_q == S_DONE);
  assign cyc_width = (size_q == SZ_B128) ? 2'd2 : size_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int CHAN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] xfer_count,
  input  logic [1:0]    xfer_size,
  input  logic          burst_mode,
  input  logic          ext_mode,
  input  logic          ext_req_n,
  input  logic          bus_gnt,
  input  logic          bus_done,
  output logic          bus_req,
  output logic          cyc_valid,
  output logic          cyc_write,
  output logic [AW-1:0] cyc_addr,
  output logic [1:0]    cyc_width,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic          xfer_end
);

  localparam bit LEVEL_OK = (CHAN <= 3);

  logic [1:0] rs_q;
  logic       srst_n;
  logic       ext_eff;
  logic       load, step, last_unit;
  unit_size_e size_q;
  logic [1:0] beat_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  generate
    if (LEVEL_OK) begin : g_level
      assign ext_eff = ext_mode;
    end else begin : g_auto_only
      assign ext_eff = 1'b0;
    end
  endgenerate

  dma_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (start),
    .cnt_zero  (xfer_count == '0),
    .size_in   (xfer_size),
    .burst_in  (burst_mode),
    .ext_in    (ext_eff),
    .ext_req_n (ext_req_n),
    .bus_gnt   (bus_gnt),
    .bus_done  (bus_done),
    .last_unit (last_unit),
    .load      (load),
    .step      (step),
    .size_q    (size_q),
    .beat_q    (beat_q),
    .bus_req   (bus_req),
    .cyc_valid (cyc_valid),
    .cyc_write (cyc_write),
    .cyc_width (cyc_width),
    .xfer_end  (xfer_end)
  );

  dma_seq_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (load),
    .step      (step),
    .src_in    (src_addr),
    .dst_in    (dst_addr),
    .cnt_in    (xfer_count),
    .size_q    (size_q),
    .sel_dst   (cyc_write),
    .beat      (beat_q),
    .last_unit (last_unit),
    .beat_addr (cyc_addr),
    .src_q     (cur_src),
    .dst_q     (cur_dst)
  );

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          burst_mode,
  input logic          ext_mode,
  input logic          bus_done,
  input logic          bus_req,
  input logic          cyc_valid,
  input logic          cyc_write,
  input logic [AW-1:0] cyc_addr,
  input logic [1:0]    cyc_width,
  input logic          xfer_end
);

  // R3: a unit opens with a read
  p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_valid) |-> !cyc_write);

  // R4: beat width never exceeds 4 bytes
  p_beat_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_width != 2'd3));

  // R6: beats only while the bus is requested
  p_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> bus_req);

  // R6: automatic burst drops the request only at the end
  p_burst_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && !ext_mode && $fell(bus_req)) |-> xfer_end);

  // R10: single-cycle end flag with the bus released
  p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (!bus_req && !cyc_valid));

  // R12: a beat holds until completed
  p_beat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !bus_done) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_write)));

endmodule

bind dma_seq dma_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_mode (burst_mode),
  .ext_mode   (ext_mode),
  .bus_done   (bus_done),
  .bus_req    (bus_req),
  .cyc_valid  (cyc_valid),
  .cyc_write  (cyc_write),
  .cyc_addr   (cyc_addr),
  .cyc_width  (cyc_width),
  .xfer_end   (xfer_end)
);

// File: tb/sim_dma_seq.sv
module sim_dma_seq;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, start1;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] xfer_count;
  logic [1:0]    xfer_size;
  logic          burst_mode, ext_mode, ext_req_n;
  logic          bus_gnt, bus_done;
  logic          bus_req, cyc_valid, cyc_write, xfer_end;
  logic [AW-1:0] cyc_addr, cur_src, cur_dst;
  logic [1:0]    cyc_width;
  logic          u1_req, u1_valid, u1_write, u1_end;
  logic [AW-1:0] u1_addr, u1_src, u1_dst;
  logic [1:0]    u1_width;

  dma_seq #(.AW(AW), .CW(CW), .CHAN(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_count(xfer_count), .xfer_size(xfer_size), .burst_mode(burst_mode),
    .ext_mode(ext_mode), .ext_req_n(ext_req_n), .bus_gnt(bus_gnt), .bus_done(bus_done),
    .bus_req(bus_req), .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_width(cyc_width), .cur_src(cur_src), .cur_dst(cur_dst), .xfer_end(xfer_end));

  dma_seq #(.AW(AW), .CW(CW), .CHAN(5)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_count(xfer_count), .xfer_size(xfer_size), .burst_mode(burst_mode),
    .ext_mode(ext_mode), .ext_req_n(ext_req_n), .bus_gnt(bus_gnt), .bus_done(bus_done),
    .bus_req(u1_req), .cyc_valid(u1_valid), .cyc_write(u1_write), .cyc_addr(u1_addr),
    .cyc_width(u1_width), .cur_src(u1_src), .cur_dst(u1_dst), .xfer_end(u1_end));

  // pseudo-random arbiter and bus
  logic [15:0] lfsr;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign bus_gnt  = lfsr[0] | lfsr[5];
  assign bus_done = lfsr[3] | lfsr[9];

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 asking, 2 reading, 3 writing, 4 dropped, 5 finished
  int          ph, bt, units;
  logic [31:0] ms, md;
  int          msz;
  bit          mburst, mext;

  function automatic int bytes_of(int s);
    return (s == 3) ? 16 : (1 << s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; bt = 0; units = 0; ms = 0; md = 0; msz = 0; mburst = 0; mext = 0;
    end else begin
      int lastb;
      lastb = (msz == 3) ? 3 : 0;
      if (ph == 0) begin
        if (start && xfer_count != 0) begin
          ms = src_addr; md = dst_addr; units = xfer_count;
          msz = xfer_size; mburst = burst_mode; mext = ext_mode; ph = 1;
        end
      end else if (ph == 1) begin
        if ((!mext || !ext_req_n) && bus_gnt) begin ph = 2; bt = 0; end
      end else if (ph == 2) begin
        if (bus_done) begin
          if (bt == lastb) begin ph = 3; bt = 0; end
          else bt++;
        end
      end else if (ph == 3) begin
        if (bus_done) begin
          if (bt == lastb) begin
            ms = ms + bytes_of(msz); md = md + bytes_of(msz);
            units--; bt = 0;
            if (units == 0) ph = 5;
            else if (!mburst || (mext && ext_req_n)) ph = 4;
            else ph = 2;
          end else bt++;
        end
      end else if (ph == 4) ph = 1;
      else ph = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit          e_req, e_val;
      logic [31:0] e_addr;
      logic [1:0]  e_w;
      e_val  = (ph == 2) || (ph == 3);
      e_req  = e_val || (ph == 1 && (!mext || !ext_req_n));
      e_addr = ((ph == 3) ? md : ms) + 32'(4 * bt);
      e_w    = (msz == 3) ? 2'd2 : 2'(msz);
      chk(bus_req == e_req, "R6 R7 R8", "bus_req", 64'(bus_req), 64'(e_req));
      chk(cyc_valid == e_val, "R3", "cyc_valid", 64'(cyc_valid), 64'(e_val));
      chk(xfer_end == (ph == 5), "R10", "xfer_end", 64'(xfer_end), 64'(ph == 5));
      chk(cur_src == ms && cur_dst == md, "R9 R5", "cur_src", 64'(cur_src), 64'(ms));
      if (e_val) begin
        chk(cyc_write == (ph == 3), "R3", "cyc_write", 64'(cyc_write), 64'(ph == 3));
        chk(cyc_addr == e_addr, "R4 R5 R12", "cyc_addr", 64'(cyc_addr), 64'(e_addr));
        chk(cyc_width == e_w, "R4", "cyc_width", 64'(cyc_width), 64'(e_w));
      end
    end
  end

  // event counters
  int  n_end, n_fall;
  bit  prev_req;
  always @(posedge clk) begin
    if (!rst_n) begin prev_req = 0; end
    else begin
      if (xfer_end) n_end++;
      if (prev_req && !bus_req) n_fall++;
      prev_req = bus_req;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic go(input logic [31:0] s, input logic [31:0] d, input int cnt,
                    input int sz, input bit bm, input bit em);
    @(negedge clk);
    src_addr = s; dst_addr = d; xfer_count = CW'(cnt); xfer_size = 2'(sz);
    burst_mode = bm; ext_mode = em; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #3;
      if (xfer_end) return;
    end
    chk(0, "R10", "end not reached", 0, 1);
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] d, input int cnt,
                     input int sz, input bit bm, input int exp_fall);
    n_end = 0; n_fall = 0;
    go(s, d, cnt, sz, bm, 1'b0);
    wait_end();
    @(negedge clk); #3;
    chk(n_end == 1, "R10", "end pulses", 64'(n_end), 1);
    chk(cur_src == s + 32'(cnt * bytes_of(sz)), "R5", "final src", 64'(cur_src),
        64'(s + 32'(cnt * bytes_of(sz))));
    chk(cur_dst == d + 32'(cnt * bytes_of(sz)), "R5", "final dst", 64'(cur_dst),
        64'(d + 32'(cnt * bytes_of(sz))));
    chk(n_fall == exp_fall, bm ? "R6" : "R7", "request drops", 64'(n_fall), 64'(exp_fall));
    chk(!bus_req && !cyc_valid, "R10", "idle after end", 64'(bus_req), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start1 = 1'b0; ext_req_n = 1'b1;
    src_addr = '0; dst_addr = '0; xfer_count = '0; xfer_size = 2'd0;
    burst_mode = 1'b0; ext_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(!bus_req && !cyc_valid && !xfer_end, "R1", "outputs after reset",
        64'({bus_req, cyc_valid, xfer_end}), 0);
    chk(cur_src == 0 && cur_dst == 0, "R1", "addresses after reset", 64'(cur_src), 0);
    repeat (3) @(negedge clk);

    // R2: zero count ignored
    go(32'h100, 32'h200, 0, 2, 1'b1, 1'b0);
    repeat (5) @(negedge clk); #3;
    chk(!bus_req, "R2", "zero count start", 64'(bus_req), 0);

    run(32'h1000, 32'h2000, 5, 2, 1'b1, 1);   // R6 burst, 32-bit
    run(32'h3001, 32'h4003, 4, 0, 1'b0, 4);   // R7 cycle steal, 8-bit
    run(32'h5000, 32'h6000, 3, 3, 1'b1, 1);   // R4 burst, 128-bit
    run(32'h7002, 32'h8000, 3, 1, 1'b0, 3);   // R7 cycle steal, 16-bit
    run(32'h9000, 32'hA000, 2, 3, 1'b0, 2);   // R4 R7 128-bit steal

    // R8 R9: level trigger burst with a pause
    ext_req_n = 1'b0;
    n_end = 0;
    go(32'hB000, 32'hC000, 10, 2, 1'b1, 1'b1);
    fork
      wait_end();
      begin
        logic [31:0] held;
        bit          seen;
        repeat (8) @(negedge clk);
        #3 ext_req_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
          @(negedge clk); #3;
          if (!bus_req) begin seen = 1; break; end
        end
        chk(seen, "R9", "bus released on high request", 64'(bus_req), 0);
        held = cur_src;
        repeat (10) @(negedge clk); #3;
        chk(cur_src == held && !bus_req, "R9", "paused state held", 64'(cur_src), 64'(held));
        chk(!bus_req, "R8", "no request while line high", 64'(bus_req), 0);
        ext_req_n = 1'b0;
      end
    join
    @(negedge clk); #3;
    chk(n_end == 1, "R9", "paused transfer completes", 64'(n_end), 1);
    chk(cur_src == 32'hB000 + 40, "R9", "resumed final src", 64'(cur_src), 64'(32'hB000 + 40));

    // R11: channel above 3 ignores the level trigger, R8 on channel 1
    @(negedge clk);
    ext_req_n = 1'b1;
    src_addr = 32'hD000; dst_addr = 32'hE000; xfer_count = 16'd2; xfer_size = 2'd2;
    burst_mode = 1'b0; ext_mode = 1'b1; start = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start = 1'b0; start1 = 1'b0;
    repeat (2) @(negedge clk); #3;
    chk(u1_req, "R11", "auto request on high channel", 64'(u1_req), 1);
    chk(!bus_req, "R8", "level trigger waits", 64'(bus_req), 0);
    n_end = 0;
    ext_req_n = 1'b0;
    wait_end();
    @(negedge clk); #3;
    chk(n_end == 1, "R8", "level transfer completes", 64'(n_end), 1);
    repeat (20) @(negedge clk);

    summary();
    $finish;
  end
endmodule